// File: doc/BRIEF.md
# Delta-Encoded Frame Builder

This block turns one captured waveform period, held in an external sample memory, into a fixed-length byte stream. It reads the samples one at a time and emits a constant marker byte, then the first sample as an absolute seed, then one signed 8-bit difference for each following sample. The stream ends with a 16-bit CCITT checksum. The checksum is accumulated while the bytes leave the block, so the frame needs no second pass and no frame buffer.

Each difference is measured against the value a decoder would have rebuilt so far, not against the raw previous sample. The difference is clamped to the 8-bit signed range. When a step is too large, the decoded value moves as far as it can and catches up on later samples, so the error does not grow along the frame. A one-cycle start request launches a frame. A valid/ready handshake paces the bytes. A one-cycle done pulse closes the frame.

Top module: `delta_frame_builder`

## Requirements
- R1: While reset is held, and afterwards until the first start request, `tx_valid_o` and `done_o` stay low.
- R2: A frame is exactly N_SAMPLES+4 bytes (304 by default), and its first byte is 0xAA.
- R3: Bytes 1 and 2 carry sample 0 zero-extended to 16 bits, high byte first. The upper 4 bits of byte 1 are zero.
- R4: Byte k+2, for k from 1 to N_SAMPLES-1, is the two's-complement difference between sample k and the running decoded value. The running value starts at sample 0 and adds each emitted difference.
- R5: A difference above +127 is sent as 0x7F and one below -128 is sent as 0x80. The running value then advances only by the clamped amount.
- R6: The last two bytes are a CRC-16 with polynomial 0x1021, initial value 0xFFFF, MSB-first bit order and no final XOR, taken over every earlier byte of the frame. It is sent high byte first.
- R7: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_data_o` and `tx_valid_o` hold. Stall patterns do not change the byte sequence.
- R8: A start request that arrives while a frame is in progress has no effect. The frame continues unchanged, and no second frame follows it.
- R9: `done_o` is high for exactly one cycle, the cycle after the handshake of the last CRC byte. In that cycle `tx_valid_o` is low.
- R10: The sample memory is read combinationally. While the difference byte for sample k is offered, `mem_addr_o` equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Frame launch request, honoured only when idle |
| mem_addr_o | output | 9 | Sample memory read address |
| mem_data_i | input | 12 | Sample memory read data, same cycle as address |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte is offered |
| tx_ready_i | input | 1 | Consumer accepts the byte this cycle |
| done_o | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions assume that `mem_data_i` reflects `mem_addr_o` within the same cycle and that the memory contents do not change while a frame is being sent. They also assume that the consumer may lower `tx_ready_i` at any time. The bench models the memory as a combinational array, and it rewrites the samples only between frames. It drives `tx_ready_i` either held high or from a pseudo-random pattern. It raises `start_i` in the middle of a frame only to test R8.

// File: rtl/delta_frame_pkg.sv
// Shared types for the delta-encoded frame builder.
package delta_frame_pkg;

    // Role of the byte at the current frame position.
    typedef enum logic [2:0] {
        SLOT_HDR     = 3'd0,
        SLOT_SEED_HI = 3'd1,
        SLOT_SEED_LO = 3'd2,
        SLOT_DELTA   = 3'd3,
        SLOT_CRC_HI  = 3'd4,
        SLOT_CRC_LO  = 3'd5
    } slot_e;

endpackage

// File: rtl/crc16_byte_step.sv
// One-byte update of an MSB-first CRC-16 with no reflection.
// Purely combinational. Assumes the caller holds the register and the seed.
module crc16_byte_step #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic [15:0] crc_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] crc_o
);
    // Shift eight bits of the byte through the polynomial.
    always_comb begin
        logic [15:0] c;
        c = crc_i ^ {byte_i, 8'h00};
        for (int b = 0; b < 8; b++) begin
            c = c[15] ? ((c << 1) ^ POLY) : (c << 1);
        end
        crc_o = c;
    end
endmodule

// File: rtl/delta_saturator.sv
// Forms the clamped signed 8-bit difference between a sample and the
// running decoded value, plus the decoded value that results from it.
// Assumes both inputs are unsigned, SAMPLE_W bits wide, with SAMPLE_W >= 8.
module delta_saturator #(
    parameter int SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [SAMPLE_W-1:0] recon_i,
    output logic [7:0]          delta_o,
    output logic [SAMPLE_W-1:0] recon_next_o
);
    localparam logic signed [SAMPLE_W:0] MAX_D = 127;
    localparam logic signed [SAMPLE_W:0] MIN_D = -128;

    logic signed [SAMPLE_W:0] diff;
    logic [SAMPLE_W:0]        sum;

    // Clamp the raw difference into the signed byte range.
    always_comb begin
        diff = $signed({1'b0, sample_i}) - $signed({1'b0, recon_i});
        if (diff > MAX_D)      delta_o = 8'h7F;
        else if (diff < MIN_D) delta_o = 8'h80;
        else                   delta_o = diff[7:0];
    end

    // Advance the decoded value by the clamped amount.
    always_comb begin
        sum          = {1'b0, recon_i} + {{(SAMPLE_W + 1 - 8){delta_o[7]}}, delta_o};
        recon_next_o = sum[SAMPLE_W-1:0];
    end
endmodule

// File: rtl/frame_sequencer.sv
// Tracks the byte position within a frame and whether a frame is running.
// A launch is accepted only while idle. Done pulses the cycle after the
// handshake of the final byte.
module frame_sequencer #(
    parameter int FRAME_LEN = 304,
    localparam int CNT_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch_i,
    input  logic             fire_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             last_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

    assign last_o = (idx_o == LAST_IDX);

    // Position counter, busy flag and end-of-frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            idx_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= fire_i && last_o;
            if (launch_i) begin
                busy_o <= 1'b1;
                idx_o  <= '0;
            end else if (fire_i) begin
                if (last_o) begin
                    busy_o <= 1'b0;
                    idx_o  <= '0;
                end else begin
                    idx_o <= idx_o + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/delta_frame_builder.sv
// Streams one period of samples as: marker, 16-bit seed, clamped 8-bit
// differences, CRC-16. Assumes a sample memory whose read data follows the
// address in the same cycle, with contents held while a frame runs.
module delta_frame_builder #(
    parameter int          N_SAMPLES = 300,
    parameter int          SAMPLE_W  = 12,
    parameter logic [7:0]  HEADER    = 8'hAA,
    parameter logic [15:0] CRC_POLY  = 16'h1021,
    parameter logic [15:0] CRC_INIT  = 16'hFFFF,
    localparam int         ADDR_W    = $clog2(N_SAMPLES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    output logic [ADDR_W-1:0]   mem_addr_o,
    input  logic [SAMPLE_W-1:0] mem_data_i,
    output logic [7:0]          tx_data_o,
    output logic                tx_valid_o,
    input  logic                tx_ready_i,
    output logic                done_o
);
    import delta_frame_pkg::*;

    localparam int FRAME_LEN = N_SAMPLES + 4;
    localparam int CNT_W     = $clog2(FRAME_LEN);

    logic                busy, last, launch, fire;
    logic [CNT_W-1:0]    idx, k_full;
    slot_e               slot;
    logic [SAMPLE_W-1:0] recon, recon_next;
    logic [7:0]          delta_byte;
    logic [15:0]         crc, crc_next, seed16;

    assign launch     = start_i && !busy;
    assign fire       = tx_valid_o && tx_ready_i;
    assign tx_valid_o = busy;
    assign k_full     = idx - CNT_W'(2);
    assign seed16     = 16'(mem_data_i);

    frame_sequencer #(.FRAME_LEN(FRAME_LEN)) seq_i (
        .clk(clk), .rst_n(rst_n), .launch_i(launch), .fire_i(fire),
        .busy_o(busy), .idx_o(idx), .last_o(last), .done_o(done_o)
    );

    delta_saturator #(.SAMPLE_W(SAMPLE_W)) sat_i (
        .sample_i(mem_data_i), .recon_i(recon),
        .delta_o(delta_byte), .recon_next_o(recon_next)
    );

    crc16_byte_step #(.POLY(CRC_POLY)) crc_i (
        .crc_i(crc), .byte_i(tx_data_o), .crc_o(crc_next)
    );

    // Classify the current frame position.
    always_comb begin
        if (idx == CNT_W'(0))                  slot = SLOT_HDR;
        else if (idx == CNT_W'(1))             slot = SLOT_SEED_HI;
        else if (idx == CNT_W'(2))             slot = SLOT_SEED_LO;
        else if (idx == CNT_W'(FRAME_LEN - 2)) slot = SLOT_CRC_HI;
        else if (idx == CNT_W'(FRAME_LEN - 1)) slot = SLOT_CRC_LO;
        else                                   slot = SLOT_DELTA;
    end

    // Point the memory at the sample the current byte needs.
    always_comb begin
        mem_addr_o = (slot == SLOT_DELTA) ? k_full[ADDR_W-1:0] : '0;
    end

    // Select the outgoing byte.
    always_comb begin
        unique case (slot)
            SLOT_HDR:     tx_data_o = HEADER;
            SLOT_SEED_HI: tx_data_o = seed16[15:8];
            SLOT_SEED_LO: tx_data_o = seed16[7:0];
            SLOT_DELTA:   tx_data_o = delta_byte;
            SLOT_CRC_HI:  tx_data_o = crc[15:8];
            default:      tx_data_o = crc[7:0];
        endcase
    end

    // Running CRC over every non-CRC byte that is handed off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc <= CRC_INIT;
        end else if (launch) begin
            crc <= CRC_INIT;
        end else if (fire && slot != SLOT_CRC_HI && slot != SLOT_CRC_LO) begin
            crc <= crc_next;
        end
    end

    // Decoded-value tracker that mirrors what a receiver rebuilds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            recon <= '0;
        end else if (fire && slot == SLOT_SEED_LO) begin
            recon <= mem_data_i;
        end else if (fire && slot == SLOT_DELTA) begin
            recon <= recon_next;
        end
    end
endmodule

// Property checker for the frame builder, observing its ports only.
module delta_frame_builder_chk #(
    parameter int         FRAME_LEN = 304,
    parameter int         ADDR_W    = 9,
    parameter logic [7:0] HEADER    = 8'hAA,
    localparam int        CNT_W     = $clog2(FRAME_LEN)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [7:0]        tx_data_o,
    input logic              tx_valid_o,
    input logic              tx_ready_i,
    input logic              done_o
);
    logic [CNT_W-1:0] pos;
    logic             hs;

    assign hs = tx_valid_o && tx_ready_i;

    // Count handed-off bytes independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n)                                     pos <= '0;
        else if (hs && pos == CNT_W'(FRAME_LEN - 1))    pos <= '0;
        else if (hs)                                    pos <= pos + 1'b1;
    end

    a_r2_header: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && pos == '0 |-> tx_data_o == HEADER);
    a_r2_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> pos == '0 && $past(pos) == CNT_W'(FRAME_LEN - 1));
    a_r3_seed_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && pos == CNT_W'(1) |-> tx_data_o[7:4] == 4'h0);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && tx_valid_o && !hs |=> tx_valid_o && $stable(pos));
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !tx_valid_o);
    a_r10_addr: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid_o && pos > CNT_W'(2) && pos < CNT_W'(FRAME_LEN - 2)
        |-> CNT_W'(mem_addr_o) == pos - CNT_W'(2));
endmodule

bind delta_frame_builder delta_frame_builder_chk #(
    .FRAME_LEN(N_SAMPLES + 4), .ADDR_W(ADDR_W), .HEADER(HEADER)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_addr_o(mem_addr_o),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
    .done_o(done_o)
);

// File: tb/delta_frame_builder_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module delta_frame_builder_tb_top;
    localparam int NS = 300;
    localparam int FL = NS + 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] mem_addr;
    logic [11:0] mem_data;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       done;

    logic [11:0] mem [0:NS-1];
    logic [7:0]  expb [0:FL-1];
    logic [7:0]  got  [0:FL-1];
    logic [15:0] lfsr = 16'hACE1;
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign mem_data = (int'(mem_addr) < NS) ? mem[mem_addr] : 12'h000;

    delta_frame_builder dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_addr_o(mem_addr),
        .mem_data_i(mem_data), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
        .tx_ready_i(tx_ready), .done_o(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    // Expected frame computed from the requirements.
    task automatic build_expected();
        int r, d;
        logic [15:0] c;
        expb[0] = 8'hAA;
        expb[1] = 8'(mem[0] >> 8);
        expb[2] = mem[0][7:0];
        r = int'(mem[0]);
        for (int k = 1; k < NS; k++) begin
            d = int'(mem[k]) - r;
            if (d > 127) d = 127;
            if (d < -128) d = -128;
            expb[k+2] = 8'(d);
            r = r + d;
        end
        c = 16'hFFFF;
        for (int i = 0; i < FL - 2; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic fb;
                fb = c[15] ^ expb[i][b];
                c = {c[14:0], 1'b0};
                if (fb) c = c ^ 16'h1021;
            end
        end
        expb[FL-2] = c[15:8];
        expb[FL-1] = c[7:0];
    endtask

    // Launch one frame, collect it and check every region.
    task automatic run_frame(input bit stall, input bit poke, input string tag);
        int n = 0, ndone = 0, tail_valid = 0, bad_hold = 0, bad_addr = 0;
        bit pv = 0;
        logic [7:0] pd = 8'h00;
        build_expected();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int cyc = 0; cyc < 4000 && n < FL; cyc++) begin
            bit r;
            if (cyc > 0) @(negedge clk);
            if (done) ndone++;
            if (pv && (!tx_valid || tx_data != pd)) bad_hold++;
            if (tx_valid && n >= 3 && n < FL - 2 && int'(mem_addr) != n - 2) bad_addr++;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = stall ? (lfsr[0] | lfsr[5]) : 1'b1;
            start_i = (poke && n == 100) ? 1'b1 : 1'b0;
            tx_ready = r;
            pv = tx_valid && !r;
            pd = tx_data;
            if (tx_valid && r) begin
                got[n] = tx_data;
                n++;
            end
        end
        start_i = 1'b0;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            if (done) ndone++;
            if (tx_valid) tail_valid++;
            if (t == 0) check(done == 1'b1 && tx_valid == 1'b0, "R9",
                              {tag, " done one cycle after last byte"}, {done, tx_valid}, 2);
        end
        tx_ready = 1'b0;
        check(n == FL, "R2", {tag, " frame byte count"}, n, FL);
        check(got[0] == 8'hAA, "R2", {tag, " header"}, got[0], 8'hAA);
        check(got[1] == expb[1] && got[2] == expb[2] && got[1][7:4] == 4'h0, "R3",
              {tag, " seed bytes"}, {got[1], got[2]}, {expb[1], expb[2]});
        begin
            int first_bad = -1;
            for (int i = 3; i < FL - 2; i++)
                if (got[i] != expb[i] && first_bad < 0) first_bad = i;
            check(first_bad < 0, "R4", {tag, " delta bytes"},
                  first_bad < 0 ? 0 : got[first_bad], first_bad < 0 ? 0 : expb[first_bad]);
        end
        check(got[FL-2] == expb[FL-2] && got[FL-1] == expb[FL-1], "R6",
              {tag, " crc bytes"}, {got[FL-2], got[FL-1]}, {expb[FL-2], expb[FL-1]});
        check(ndone == 1, "R9", {tag, " single done pulse"}, ndone, 1);
        check(tail_valid == 0, "R8", {tag, " no second frame after done"}, tail_valid, 0);
        check(bad_addr == 0, "R10", {tag, " memory address tracks sample"}, bad_addr, 0);
        if (stall) check(bad_hold == 0, "R7", {tag, " byte held while stalled"}, bad_hold, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b0 && done == 1'b0, "R1", "outputs in reset", {tx_valid, done}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(tx_valid == 1'b0 && done == 1'b0, "R1", "idle after reset", {tx_valid, done}, 0);
    endtask

    task automatic t_smooth();
        for (int i = 0; i < NS; i++) begin
            int ph = i % 100;
            mem[i] = 12'(1500 + (ph < 50 ? ph * 20 : (100 - ph) * 20));
        end
        run_frame(1'b0, 1'b0, "smooth");
    endtask

    task automatic t_sat_up();
        for (int i = 0; i < NS; i++) mem[i] = (i % 2 == 0) ? 12'd0 : 12'd4095;
        run_frame(1'b0, 1'b0, "sat_up");
        check(got[3] == 8'h7F, "R5", "first step clamps to +127", got[3], 8'h7F);
        check(got[4] == 8'h81, "R5", "step back from clamped value", got[4], 8'h81);
    endtask

    task automatic t_sat_down();
        for (int i = 0; i < NS; i++) mem[i] = 12'd0;
        mem[0] = 12'd4095;
        run_frame(1'b0, 1'b0, "sat_down");
        check(got[3] == 8'h80, "R5", "large fall clamps to -128", got[3], 8'h80);
        check(got[34] == 8'h81 && got[35] == 8'h00, "R5", "catch-up after clamping",
              {got[34], got[35]}, 16'h8100);
    endtask

    task automatic t_stall();
        for (int i = 0; i < NS; i++) mem[i] = 12'((i * 37 + 11) % 4096);
        run_frame(1'b1, 1'b0, "stall");
    endtask

    task automatic t_restart_ignored();
        for (int i = 0; i < NS; i++) mem[i] = 12'(4000 - i * 9);
        run_frame(1'b1, 1'b1, "restart");
    endtask

    initial begin
        t_reset();
        t_smooth();
        t_sat_up();
        t_sat_down();
        t_stall();
        t_restart_ignored();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule